// File: doc/BRIEF.md
# ECC Translating Memory Endpoint

This block is the last ECC-protected stop for 64-bit data on its way into and out of a local memory array. The internal data path protects each word with eight SEC/DED check bits. The array stores the same word under a second SEC/DED code that uses a different H-matrix. Because the block is an endpoint, it repairs faults instead of forwarding them.

On a write, the incoming word is checked against the internal code. A single-bit fault is repaired before the word is re-encoded into the storage code. A word that cannot be repaired is stored with a deliberately poisoned storage code word. On a read, the stored word is checked against the storage code and repaired where possible. It is then returned under the internal code with fresh check bits, or with poisoned check bits if it could not be repaired.

Each direction keeps sticky status for correctable and uncorrectable events, plus the address of the first failing access. A write-one-to-clear strobe resets this status. A fault-mask input can flip bits of the stored code word, which lets the read path be exercised against damaged storage.

Top module: `ecc_xlate_top`

## Requirements
- R1: When write data has exactly one flipped bit, in either the data or the check field, the block repairs it before storage encoding, and a later read returns the original word. The internal code's data-bit columns are all 56 weight-3 bytes in ascending order, followed by the 8 smallest weight-5 bytes in ascending order. Check bit j has the column 1<<j, and each check bit is the even parity of the data bits whose column has that bit set.
- R2: When write data has an even-weight nonzero syndrome, the block stores the received data unchanged with a storage check field XORed with the poison pattern 8'hFF, and flags a write uncorrectable event.
- R3: A single flipped bit in the stored word is repaired on read, and the response carries valid internal check bits. The fault mask st_fault places data in bits [63:0] and the storage check field in bits [71:64].
- R4: A stored word that cannot be repaired is returned with its data unmodified and with check bits equal to the internal encoding of that data XOR 8'hFF.
- R5: A poisoned stored word that takes one further flip in its check field still reads as uncorrectable.
- R6: A read response appears exactly one cycle after its request, and only then. A write takes effect at its request edge, so a read issued in the next cycle sees it.
- R7: Status bits are sticky. stat_clr bit 0 clears write-correctable, bit 1 clears write-uncorrectable, bit 2 clears read-correctable and bit 3 clears read-uncorrectable. A new event in the same cycle as its clear leaves the bit set.
- R8: The error address of a path is captured only on an event that finds both of that path's status bits clear (after any same-cycle clear). Later events leave the address alone.
- R9: A read and a write to the same address in the same cycle return the word that was stored before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_addr | input | AW | Write address |
| wr_data | input | 64 | Write data under the internal code |
| wr_chk | input | 8 | Internal check bits of the write data |
| st_fault | input | 72 | XOR mask applied to the stored code word (data in [63:0], check in [71:64]) |
| rd_valid | input | 1 | Read request |
| rd_addr | input | AW | Read address |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 64 | Read response data |
| rsp_chk | output | 8 | Read response internal check bits |
| stat_clr | input | 4 | Write-one-to-clear strobe for the four status bits |
| wr_ce | output | 1 | Sticky write correctable status |
| wr_ue | output | 1 | Sticky write uncorrectable status |
| wr_err_addr | output | AW | Address of the first failing write |
| rd_ce | output | 1 | Sticky read correctable status |
| rd_ue | output | 1 | Sticky read uncorrectable status |
| rd_err_addr | output | AW | Address of the first failing read |

## Verification
Two pairs of functions can coincide in one cycle: a write and a read to the same address, and a status clear together with a fresh event on the same path. The bench provokes the first by driving both requests on one edge. It judges the result by the scoreboard expecting the older word, followed by the newer one on the next read. It provokes the second by raising the clear strobe in the same cycle as a write carrying a single-bit fault. It then expects the status bit to remain set and the error address to move to the new write.

// File: rtl/ecc_xlate_pkg.sv
package ecc_xlate_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int WORD_W = DATA_W + CHK_W;

  typedef struct packed {
    logic [CHK_W-1:0]  chk;
    logic [DATA_W-1:0] data;
  } cword_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              ce;
    logic              ue;
  } fix_t;

  function automatic int pop8(logic [7:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 8; i++) if (v[i]) n++;
    return n;
  endfunction

  // Column idx of the unrotated matrix: weight-3 bytes ascending, then weight-5 bytes.
  function automatic logic [CHK_W-1:0] base_col(int idx);
    int seen;
    logic [7:0] col;
    seen = 0;
    col  = '0;
    for (int w = 3; w <= 5; w += 2)
      for (int v = 1; v < 256; v++)
        if (pop8(8'(v)) == w) begin
          if (seen == idx) col = 8'(v);
          seen++;
        end
    return col;
  endfunction

  function automatic logic [CHK_W-1:0] rot_col(logic [CHK_W-1:0] v, int r);
    logic [CHK_W-1:0] o;
    o = v;
    for (int k = 0; k < (r % CHK_W); k++) o = {o[CHK_W-2:0], o[CHK_W-1]};
    return o;
  endfunction

  function automatic logic [CHK_W-1:0] h_col(int idx, int rot);
    return rot_col(base_col(idx), rot);
  endfunction

  function automatic logic [CHK_W-1:0] ecc_gen(logic [DATA_W-1:0] d, int rot);
    logic [CHK_W-1:0] p;
    p = '0;
    for (int i = 0; i < DATA_W; i++) if (d[i]) p ^= h_col(i, rot);
    return p;
  endfunction

  function automatic logic [CHK_W-1:0] syndrome(cword_t w, int rot);
    return w.chk ^ ecc_gen(w.data, rot);
  endfunction

  function automatic fix_t ecc_fix(cword_t w, int rot);
    fix_t f;
    logic [CHK_W-1:0] syn;
    logic hit;
    syn    = syndrome(w, rot);
    f.data = w.data;
    f.ce   = 1'b0;
    f.ue   = 1'b0;
    hit    = 1'b0;
    if (syn != '0) begin
      if ((pop8(syn) % 2) == 0) begin
        f.ue = 1'b1;
      end else if ($onehot(syn)) begin
        f.ce = 1'b1;
      end else begin
        for (int i = 0; i < DATA_W; i++)
          if (h_col(i, rot) == syn) begin
            f.data[i] = ~f.data[i];
            hit = 1'b1;
          end
        f.ce = hit;
        f.ue = !hit;
      end
    end
    return f;
  endfunction
endpackage

// File: rtl/ecc_xlate_mem.sv
module ecc_xlate_mem #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int W     = 72
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wword,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rword
);
  logic [W-1:0] cells [DEPTH];

  // Read-first: a same-edge write is not visible to the read.
  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wword;
    if (re) rword <= cells[raddr];
  end
endmodule

// File: rtl/ecc_xlate_wpath.sv
module ecc_xlate_wpath
  import ecc_xlate_pkg::*;
#(
  parameter int               AW     = 4,
  parameter int               ROT    = 3,
  parameter logic [CHK_W-1:0] POISON = 8'hFF
) (
  input  logic              wr_valid,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CHK_W-1:0]  wr_chk,
  input  logic [WORD_W-1:0] st_fault,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [WORD_W-1:0] mem_wword,
  output logic              ce_evt,
  output logic              ue_evt
);
  cword_t in_w;
  cword_t st_w;
  fix_t   fx;

  always_comb begin
    in_w.data = wr_data;
    in_w.chk  = wr_chk;
    fx        = ecc_fix(in_w, 0);
    st_w.data = fx.data;
    st_w.chk  = ecc_gen(fx.data, ROT) ^ (fx.ue ? POISON : '0);
    mem_wword = st_w ^ st_fault;
  end

  assign mem_we    = wr_valid;
  assign mem_waddr = wr_addr;
  assign ce_evt    = wr_valid & fx.ce;
  assign ue_evt    = wr_valid & fx.ue;
endmodule

// File: rtl/ecc_xlate_rpath.sv
module ecc_xlate_rpath
  import ecc_xlate_pkg::*;
#(
  parameter int               AW     = 4,
  parameter int               ROT    = 3,
  parameter logic [CHK_W-1:0] POISON = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [AW-1:0]     rd_addr,
  input  logic [WORD_W-1:0] mem_rword,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [CHK_W-1:0]  rsp_chk,
  output logic              ce_evt,
  output logic              ue_evt,
  output logic [AW-1:0]     evt_addr
);
  logic          vld_q;
  logic [AW-1:0] addr_q;
  fix_t          fx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      vld_q <= rd_valid;
      if (rd_valid) addr_q <= rd_addr;
    end
  end

  always_comb begin
    fx       = ecc_fix(cword_t'(mem_rword), ROT);
    rsp_data = fx.data;
    rsp_chk  = ecc_gen(fx.data, 0) ^ (fx.ue ? POISON : '0);
  end

  assign rsp_valid = vld_q;
  assign ce_evt    = vld_q & fx.ce;
  assign ue_evt    = vld_q & fx.ue;
  assign evt_addr  = addr_q;
endmodule

// File: rtl/ecc_xlate_log.sv
module ecc_xlate_log #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_evt,
  input  logic          ue_evt,
  input  logic [AW-1:0] evt_addr,
  input  logic          clr_ce,
  input  logic          clr_ue,
  output logic          ce,
  output logic          ue,
  output logic [AW-1:0] err_addr
);
  logic keep_ce, keep_ue, armed;

  assign keep_ce = ce & ~clr_ce;
  assign keep_ue = ue & ~clr_ue;
  assign armed   = ~(keep_ce | keep_ue);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce       <= 1'b0;
      ue       <= 1'b0;
      err_addr <= '0;
    end else begin
      ce <= keep_ce | ce_evt;
      ue <= keep_ue | ue_evt;
      if ((ce_evt | ue_evt) && armed) err_addr <= evt_addr;
    end
  end
endmodule

// File: rtl/ecc_xlate_top.sv
module ecc_xlate_top
  import ecc_xlate_pkg::*;
#(
  parameter int               DEPTH     = 16,
  parameter int               STORE_ROT = 3,
  parameter logic [CHK_W-1:0] POISON    = 8'hFF,
  localparam int              AW        = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CHK_W-1:0]  wr_chk,
  input  logic [WORD_W-1:0] st_fault,
  input  logic              rd_valid,
  input  logic [AW-1:0]     rd_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [CHK_W-1:0]  rsp_chk,
  input  logic [3:0]        stat_clr,
  output logic              wr_ce,
  output logic              wr_ue,
  output logic [AW-1:0]     wr_err_addr,
  output logic              rd_ce,
  output logic              rd_ue,
  output logic [AW-1:0]     rd_err_addr
);
  logic              mem_we;
  logic [AW-1:0]     mem_waddr;
  logic [WORD_W-1:0] mem_wword;
  logic [WORD_W-1:0] mem_rword;
  logic              wr_ce_evt, wr_ue_evt;
  logic              rd_ce_evt, rd_ue_evt;
  logic [AW-1:0]     rd_evt_addr;

  ecc_xlate_wpath #(.AW(AW), .ROT(STORE_ROT), .POISON(POISON)) u_wpath (
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_chk   (wr_chk),
    .st_fault (st_fault),
    .mem_we   (mem_we),
    .mem_waddr(mem_waddr),
    .mem_wword(mem_wword),
    .ce_evt   (wr_ce_evt),
    .ue_evt   (wr_ue_evt)
  );

  ecc_xlate_mem #(.DEPTH(DEPTH), .AW(AW), .W(WORD_W)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wword(mem_wword),
    .re   (rd_valid),
    .raddr(rd_addr),
    .rword(mem_rword)
  );

  ecc_xlate_rpath #(.AW(AW), .ROT(STORE_ROT), .POISON(POISON)) u_rpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .mem_rword(mem_rword),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data),
    .rsp_chk  (rsp_chk),
    .ce_evt   (rd_ce_evt),
    .ue_evt   (rd_ue_evt),
    .evt_addr (rd_evt_addr)
  );

  ecc_xlate_log #(.AW(AW)) u_wlog (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_evt  (wr_ce_evt),
    .ue_evt  (wr_ue_evt),
    .evt_addr(wr_addr),
    .clr_ce  (stat_clr[0]),
    .clr_ue  (stat_clr[1]),
    .ce      (wr_ce),
    .ue      (wr_ue),
    .err_addr(wr_err_addr)
  );

  ecc_xlate_log #(.AW(AW)) u_rlog (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_evt  (rd_ce_evt),
    .ue_evt  (rd_ue_evt),
    .evt_addr(rd_evt_addr),
    .clr_ce  (stat_clr[2]),
    .clr_ue  (stat_clr[3]),
    .ce      (rd_ce),
    .ue      (rd_ue),
    .err_addr(rd_err_addr)
  );
endmodule

// File: rtl/ecc_xlate_chk.sv
module ecc_xlate_chk
  import ecc_xlate_pkg::*;
#(
  parameter int               ROT    = 3,
  parameter logic [CHK_W-1:0] POISON = 8'hFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_valid,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic [CHK_W-1:0]  rsp_chk,
  input logic              rd_ue_evt,
  input logic              wr_ce_evt,
  input logic              wr_ue_evt,
  input logic              mem_we,
  input logic [WORD_W-1:0] mem_wword,
  input logic [WORD_W-1:0] st_fault,
  input logic              wr_ue,
  input logic              rd_ce,
  input logic [3:0]        stat_clr
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rsp_valid);  // R6
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rsp_valid);  // R6
  AST_RSP_CLEAN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rd_ue_evt) |-> (ecc_gen(rsp_data, 0) == rsp_chk));  // R3
  AST_RSP_POISON_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rd_ue_evt) |-> ((ecc_gen(rsp_data, 0) ^ rsp_chk) == POISON));  // R4
  AST_WR_STORE_POISON: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && wr_ue_evt && (st_fault == '0)) |->
      ((mem_wword[WORD_W-1:DATA_W] ^ ecc_gen(mem_wword[DATA_W-1:0], ROT)) == POISON));  // R2
  AST_WR_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ce_evt && wr_ue_evt));  // R1
  AST_WR_UE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ue_evt |=> wr_ue);  // R7
  AST_RD_CE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ce && !stat_clr[2]) |=> rd_ce);  // R7
endmodule

bind ecc_xlate_top ecc_xlate_chk #(.ROT(STORE_ROT), .POISON(POISON)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_valid (rd_valid),
  .rsp_valid(rsp_valid),
  .rsp_data (rsp_data),
  .rsp_chk  (rsp_chk),
  .rd_ue_evt(rd_ue_evt),
  .wr_ce_evt(wr_ce_evt),
  .wr_ue_evt(wr_ue_evt),
  .mem_we   (mem_we),
  .mem_wword(mem_wword),
  .st_fault (st_fault),
  .wr_ue    (wr_ue),
  .rd_ce    (rd_ce),
  .stat_clr (stat_clr)
);

// File: tb/test_ecc_xlate_top.sv
`timescale 1ns/1ps
module test_ecc_xlate_top;
  localparam int AW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_chk = '0;
  logic [71:0] st_fault = '0;
  logic        rd_valid = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic [7:0]  rsp_chk;
  logic [3:0]  stat_clr = '0;
  logic        wr_ce, wr_ue, rd_ce, rd_ue;
  logic [AW-1:0] wr_err_addr, rd_err_addr;

  always #2 clk = ~clk;

  ecc_xlate_top i_ecc_xlate_top (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_chk(wr_chk), .st_fault(st_fault),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_chk(rsp_chk), .stat_clr(stat_clr),
    .wr_ce(wr_ce), .wr_ue(wr_ue), .wr_err_addr(wr_err_addr),
    .rd_ce(rd_ce), .rd_ue(rd_ue), .rd_err_addr(rd_err_addr)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [63:0] par_mask [8];

  logic [63:0] q_data [$];
  logic [7:0]  q_chk  [$];
  string       q_tag  [$];

  // Parity masks per check bit, built from the column rule of R1.
  task automatic build_masks();
    int cnt = 0;
    for (int j = 0; j < 8; j++) par_mask[j] = '0;
    for (int w = 3; w <= 5; w += 2)
      for (int v = 1; v < 256; v++)
        if ($countones(8'(v)) == w && cnt < 64) begin
          for (int j = 0; j < 8; j++) if (v[j]) par_mask[j][cnt] = 1'b1;
          cnt++;
        end
  endtask

  function automatic logic [7:0] icode(logic [63:0] d);
    logic [7:0] c;
    for (int j = 0; j < 8; j++) c[j] = ^(d & par_mask[j]);
    return c;
  endfunction

  task automatic check(string req, string what, logic [71:0] act, logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_wr(logic [AW-1:0] a, logic [63:0] d, logic [7:0] c,
                       logic [71:0] flt, logic [3:0] clr);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_chk = c; st_fault = flt; stat_clr = clr;
    @(negedge clk);
    wr_valid = 1'b0; st_fault = '0; stat_clr = '0;
  endtask

  task automatic do_rd(logic [AW-1:0] a, logic [63:0] ed, logic [7:0] ec, string tag);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    q_data.push_back(ed); q_chk.push_back(ec); q_tag.push_back(tag);
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic do_clr(logic [3:0] m);
    @(negedge clk);
    stat_clr = m;
    @(negedge clk);
    stat_clr = '0;
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_data.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R6 unexpected response: actual=%h expected=none", rsp_data);
      end else begin
        logic [63:0] ed;
        logic [7:0]  ec;
        string tg;
        ed = q_data.pop_front(); ec = q_chk.pop_front(); tg = q_tag.pop_front();
        check(tg, "response", {rsp_chk, rsp_data}, {ec, ed});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d1, d2, d3, d4, d5, d6, d7, d8, d9, d10, bad;
    build_masks();
    d1 = 64'h0123_4567_89AB_CDEF; d2 = 64'hFFFF_FFFF_FFFF_FFFF;
    d3 = 64'hDEAD_BEEF_0BAD_F00D; d4 = 64'h0000_0000_0000_0000;
    d5 = 64'h5A5A_A5A5_3C3C_C3C3; d6 = 64'h1357_9BDF_2468_ACE0;
    d7 = 64'h8000_0000_0000_0001; d8 = 64'h7777_1111_EEEE_2222;
    d9 = 64'hCAFE_F00D_1234_5678; d10 = 64'h0F0F_0F0F_F0F0_F0F0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", "reset status", {rsp_valid, wr_ce, wr_ue, rd_ce, rd_ue}, '0);
    check("R8", "reset addrs", {wr_err_addr, rd_err_addr}, '0);

    // Clean traffic, several patterns; write lands before next-cycle read.
    do_wr(0, d1, icode(d1), '0, '0); do_rd(0, d1, icode(d1), "R6");
    do_wr(1, d2, icode(d2), '0, '0); do_rd(1, d2, icode(d2), "R3");
    do_wr(2, d4, icode(d4), '0, '0); do_rd(2, d4, icode(d4), "R3");
    @(negedge clk);
    check("R7", "no events on clean traffic", {wr_ce, wr_ue, rd_ce, rd_ue}, '0);

    // Single-bit write faults: data bit and check bit.
    do_wr(3, d3 ^ (64'h1 << 17), icode(d3), '0, '0);
    check("R1", "write ce set", {wr_ce, wr_ue}, 2'b10);
    check("R8", "write first addr", wr_err_addr, 3);
    do_rd(3, d3, icode(d3), "R1");
    do_wr(4, d5, icode(d5) ^ 8'h10, '0, '0);
    do_rd(4, d5, icode(d5), "R1");
    check("R8", "write addr kept", wr_err_addr, 3);

    // Double-bit write fault: poisoned storage, poisoned read.
    bad = d6 ^ (64'h3 << 40);
    do_wr(5, bad, icode(d6), '0, '0);
    check("R2", "write ue set", wr_ue, 1);
    do_rd(5, bad, icode(bad) ^ 8'hFF, "R2");
    @(negedge clk);
    check("R4", "read ue set", {rd_ce, rd_ue}, 2'b01);
    check("R8", "read first addr", rd_err_addr, 5);

    do_clr(4'hF);
    check("R7", "cleared", {wr_ce, wr_ue, rd_ce, rd_ue}, '0);

    // Storage faults repaired on read.
    do_wr(6, d7, icode(d7), 72'h1 << 9, '0);
    do_rd(6, d7, icode(d7), "R3");
    @(negedge clk);
    check("R3", "read ce set", {rd_ce, rd_ue, wr_ce}, 3'b100);
    check("R8", "read addr", rd_err_addr, 6);
    do_wr(7, d8, icode(d8), 72'h1 << 66, '0);
    do_rd(7, d8, icode(d8), "R3");

    // Double storage fault: uncorrectable on read.
    bad = d9 ^ (64'h1 << 3) ^ (64'h1 << 50);
    do_wr(8, d9, icode(d9), (72'h1 << 3) | (72'h1 << 50), '0);
    do_rd(8, bad, icode(bad) ^ 8'hFF, "R4");
    @(negedge clk);
    check("R4", "read ue", rd_ue, 1);
    check("R8", "read addr kept", rd_err_addr, 6);

    // Poisoned word plus one check-field flip remains uncorrectable.
    bad = d10 ^ (64'h3 << 10);
    do_wr(9, bad, icode(d10), 72'h1 << 69, '0);
    do_rd(9, bad, icode(bad) ^ 8'hFF, "R5");

    // Same-cycle read and write to one address.
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 0; wr_data = d10; wr_chk = icode(d10);
    rd_valid = 1'b1; rd_addr = 0;
    q_data.push_back(d1); q_chk.push_back(icode(d1)); q_tag.push_back("R9");
    @(negedge clk);
    wr_valid = 1'b0; rd_valid = 1'b0;
    do_rd(0, d10, icode(d10), "R9");

    // Clear and new event together: set wins, address recaptured.
    do_clr(4'hF);
    do_wr(11, d1 ^ 64'h4, icode(d1), '0, '0);
    check("R8", "addr before clear", wr_err_addr, 11);
    do_wr(10, d2 ^ 64'h8, icode(d2), '0, 4'b0011);
    check("R7", "set wins over clear", {wr_ce, wr_ue}, 2'b10);
    check("R8", "addr recaptured", wr_err_addr, 10);
    do_rd(10, d2, icode(d2), "R1");

    repeat (3) @(negedge clk);
    check("R6", "scoreboard drained", q_data.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule